// File: doc/BRIEF.md
# Multi-View Partial-Write Register File

This block holds sixteen 64-bit general-purpose registers and lets every port address a register through one of five views: the whole word, the low 32 bits, the low 16 bits, the low byte, or the byte at bits 15:8. It has one write port, which is registered on the rising clock edge, and two combinational read ports. A read through a narrow view returns the selected field zero-extended to 64 bits.

What a write does to the bits outside its view depends on the view. A 32-bit write clears bits 63:32. A 16-bit write and the two byte writes leave every other bit unchanged. Only registers 0 to 3 have the upper byte view. A write through that view to any other index is dropped and raises a one-cycle error pulse.

Top module: `aliased_regfile`

## Requirements
- R1: Synchronous active-high reset sets all sixteen registers to zero. A read of any register after reset returns zero.
- R2: When write enable is high, a write with view code 0 (64-bit) replaces all 64 bits of the indexed register at the next rising edge.
- R3: A write with view code 1 (32-bit) stores the value's bits 31:0 into bits 31:0 and sets bits 63:32 to zero.
- R4: A write with view code 2 (16-bit) replaces bits 15:0 and keeps bits 63:16.
- R5: A write with view code 3 (low byte) replaces bits 7:0 and keeps all other bits.
- R6: A write with view code 4 (upper byte) places value bits 7:0 into bits 15:8 and keeps bits 63:16 and 7:0.
- R7: A read returns a field of the stored word, zero-extended. View 0 returns the whole word, view 1 bits 31:0, view 2 bits 15:0, view 3 bits 7:0 and view 4 bits 15:8 placed at result bits 7:0. Codes 5 to 7 return zero.
- R8: A write with view code 5, 6 or 7 changes no register.
- R9: A write with view code 4 to an index from 4 to 15 changes no register. It drives wr_err high for exactly the one cycle after the edge that sampled the write. wr_err is low at all other times.
- R10: A read of the index being written in the same cycle returns the value held before the write. There is no bypass. Both read ports behave the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_view | input | 3 | Write view code |
| wr_data | input | 64 | Write value, right-aligned |
| wr_err | output | 1 | Pulse for an illegal upper-byte write |
| ra_idx | input | 4 | Read port A index |
| ra_view | input | 3 | Read port A view code |
| ra_data | output | 64 | Read port A result |
| rb_idx | input | 4 | Read port B index |
| rb_view | input | 3 | Read port B view code |
| rb_data | output | 64 | Read port B result |

## Verification
The read ports are combinational, so a read result is due in the same cycle its index and view are applied. A write shows on the read ports one cycle later, after the edge that samples it. wr_err rises at that same edge and falls at the next one. The bench drives inputs on the falling edge. It checks a write's effect after the following rising edge by sampling at the next falling edge. It checks the old value in the same cycle as the write, before the edge. It checks wr_err both one cycle and two cycles after an illegal write, to confirm a single-cycle pulse.

// File: rtl/arf_pkg.sv
package arf_pkg;
    localparam int unsigned XLEN     = 64;
    localparam int unsigned NREGS    = 16;
    localparam int unsigned IDX_W    = $clog2(NREGS);
    localparam int unsigned VIEW_W   = 3;
    localparam int unsigned HB_LIMIT = 4;

    typedef enum logic [VIEW_W-1:0] {
        V_FULL = 3'd0,
        V_W32  = 3'd1,
        V_W16  = 3'd2,
        V_LO8  = 3'd3,
        V_HI8  = 3'd4
    } view_e;

    typedef struct packed {
        logic            legal;
        logic            zero_upper;
        logic [XLEN-1:0] keep_mask;
        logic [XLEN-1:0] ins_mask;
    } wdec_t;
endpackage

// File: rtl/arf_view_read.sv
module arf_view_read
    import arf_pkg::*;
(
    input  logic [XLEN-1:0]   word_i,
    input  logic [VIEW_W-1:0] view_i,
    output logic [XLEN-1:0]   field_o
);
    always_comb begin
        field_o = '0;
        case (view_i)
            V_FULL: field_o = word_i;
            V_W32:  field_o[31:0] = word_i[31:0];
            V_W16:  field_o[15:0] = word_i[15:0];
            V_LO8:  field_o[7:0]  = word_i[7:0];
            V_HI8:  field_o[7:0]  = word_i[15:8];
            default: field_o = '0;
        endcase
    end
endmodule

// File: rtl/arf_write_merge.sv
module arf_write_merge
    import arf_pkg::*;
(
    input  logic [XLEN-1:0]   old_i,
    input  logic [XLEN-1:0]   data_i,
    input  logic [VIEW_W-1:0] view_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic              legal_o,
    output logic              hb_bad_o,
    output logic [XLEN-1:0]   new_o
);
    wdec_t            dec;
    logic [XLEN-1:0]  placed;
    logic             hb_ok;

    assign hb_ok = (idx_i < IDX_W'(HB_LIMIT));

    always_comb begin
        dec        = '0;
        placed     = data_i;
        hb_bad_o   = 1'b0;
        case (view_i)
            V_FULL: begin
                dec.legal    = 1'b1;
                dec.ins_mask = '1;
            end
            V_W32: begin
                dec.legal      = 1'b1;
                dec.zero_upper = 1'b1;
                dec.ins_mask   = XLEN'(64'h0000_0000_FFFF_FFFF);
            end
            V_W16: begin
                dec.legal     = 1'b1;
                dec.ins_mask  = XLEN'(64'h0000_0000_0000_FFFF);
                dec.keep_mask = ~dec.ins_mask;
            end
            V_LO8: begin
                dec.legal     = 1'b1;
                dec.ins_mask  = XLEN'(64'h0000_0000_0000_00FF);
                dec.keep_mask = ~dec.ins_mask;
            end
            V_HI8: begin
                dec.legal     = hb_ok;
                hb_bad_o      = ~hb_ok;
                placed        = data_i << 8;
                dec.ins_mask  = XLEN'(64'h0000_0000_0000_FF00);
                dec.keep_mask = ~dec.ins_mask;
            end
            default: dec = '0;
        endcase
        legal_o = dec.legal;
        new_o   = (old_i & dec.keep_mask) | (placed & dec.ins_mask);
        if (!dec.legal) new_o = old_i;
    end
endmodule

// File: rtl/aliased_regfile.sv
module aliased_regfile
    import arf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [2:0]        wr_view,
    input  logic [63:0]       wr_data,
    output logic              wr_err,
    input  logic [3:0]        ra_idx,
    input  logic [2:0]        ra_view,
    output logic [63:0]       ra_data,
    input  logic [3:0]        rb_idx,
    input  logic [2:0]        rb_view,
    output logic [63:0]       rb_data
);
    typedef struct packed {
        logic [NREGS-1:0][XLEN-1:0] regs;
        logic                        err;
    } state_t;

    state_t st_d, st_q;
    logic [XLEN-1:0] merged;
    logic            legal, hb_bad;

    arf_write_merge u_merge (
        .old_i   (st_q.regs[wr_idx]),
        .data_i  (wr_data),
        .view_i  (wr_view),
        .idx_i   (wr_idx),
        .legal_o (legal),
        .hb_bad_o(hb_bad),
        .new_o   (merged)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = wr_en & hb_bad;
        if (wr_en && legal) st_d.regs[wr_idx] = merged;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wr_err = st_q.err;

    arf_view_read u_rda (.word_i(st_q.regs[ra_idx]), .view_i(ra_view), .field_o(ra_data));
    arf_view_read u_rdb (.word_i(st_q.regs[rb_idx]), .view_i(rb_view), .field_o(rb_data));

    // R9
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> !wr_err || $past(wr_en && wr_view == 3'd4 && wr_idx >= 4'd4));
    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_view == 3'd4 && wr_idx >= 4'd4) |=> wr_err);
    // R8
    noop_view_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_view > 3'd4) |=> $stable(st_q.regs));
    // R3
    w32_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_view == 3'd1) |=> st_q.regs[$past(wr_idx)][63:32] == '0);
    // R4
    w16_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_view == 3'd2) |=>
            st_q.regs[$past(wr_idx)][63:16] == $past(st_q.regs[wr_idx][63:16]));
    // R7
    rd_narrow_chk: assert property (@(posedge clk) disable iff (rst)
        (ra_view == 3'd3) |-> ra_data[63:8] == '0);
endmodule

// File: tb/sim_aliased_regfile.sv
module sim_aliased_regfile;
    localparam time TCK = 10ns;

    logic        clk = 0, rst = 1;
    logic        wr_en = 0;
    logic [3:0]  wr_idx = 0, ra_idx = 0, rb_idx = 0;
    logic [2:0]  wr_view = 0, ra_view = 0, rb_view = 0;
    logic [63:0] wr_data = 0;
    logic        wr_err;
    logic [63:0] ra_data, rb_data;
    int          n_chk = 0, n_bad = 0;
    logic [63:0] shadow [16];

    aliased_regfile u0 (.*);

    always #(TCK/2) clk = ~clk;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] i, logic [2:0] v, logic [63:0] d);
        wr_en = 1; wr_idx = i; wr_view = v; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(string req, logic [3:0] i, logic [2:0] v, logic [63:0] exp);
        ra_idx = i; ra_view = v; rb_idx = i; rb_view = v;
        #1;
        chk(req, ra_data, exp);
        chk(req, rb_data, exp);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 16; i++) rd("R1", i[3:0], 3'd0, 64'h0);
        chk("R1", {63'h0, wr_err}, 64'h0);
    endtask

    task automatic t_full;
        wr(4'd2, 3'd0, 64'hFEDC_BA98_7654_3210);
        rd("R2", 4'd2, 3'd0, 64'hFEDC_BA98_7654_3210);
        rd("R7", 4'd2, 3'd1, 64'h7654_3210);
        rd("R7", 4'd2, 3'd2, 64'h3210);
        rd("R7", 4'd2, 3'd3, 64'h10);
        rd("R7", 4'd2, 3'd4, 64'h32);
        rd("R7", 4'd2, 3'd6, 64'h0);
    endtask

    task automatic t_w32;
        wr(4'd5, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(4'd5, 3'd1, 64'hAAAA_AAAA_1234_5678);
        rd("R3", 4'd5, 3'd0, 64'h0000_0000_1234_5678);
    endtask

    task automatic t_w16;
        wr(4'd6, 3'd0, 64'h1111_2222_3333_4444);
        wr(4'd6, 3'd2, 64'hFFFF_FFFF_FFFF_ABCD);
        rd("R4", 4'd6, 3'd0, 64'h1111_2222_3333_ABCD);
    endtask

    task automatic t_bytes;
        wr(4'd1, 3'd0, 64'h0102_0304_0506_0708);
        wr(4'd1, 3'd3, 64'hFFFF_FFFF_FFFF_FF99);
        rd("R5", 4'd1, 3'd0, 64'h0102_0304_0506_0799);
        wr(4'd1, 3'd4, 64'hFFFF_FFFF_FFFF_FF5A);
        rd("R6", 4'd1, 3'd0, 64'h0102_0304_0506_5A99);
        wr(4'd3, 3'd4, 64'h00C3);
        rd("R6", 4'd3, 3'd0, 64'hC300);
    endtask

    task automatic t_noop;
        wr(4'd7, 3'd0, 64'hDEAD_BEEF_CAFE_F00D);
        wr(4'd7, 3'd5, 64'h0);
        wr(4'd7, 3'd7, 64'h0);
        rd("R8", 4'd7, 3'd0, 64'hDEAD_BEEF_CAFE_F00D);
    endtask

    task automatic t_hb_err;
        wr(4'd8, 3'd0, 64'h0000_0000_0000_1234);
        chk("R9", {63'h0, wr_err}, 64'h0);
        wr(4'd8, 3'd4, 64'h00EE);
        chk("R9", {63'h0, wr_err}, 64'h1);
        rd("R9", 4'd8, 3'd0, 64'h1234);
        @(negedge clk);
        chk("R9", {63'h0, wr_err}, 64'h0);
    endtask

    task automatic t_no_bypass;
        wr(4'd9, 3'd0, 64'h5555);
        wr_en = 1; wr_idx = 4'd9; wr_view = 3'd0; wr_data = 64'h7777;
        ra_idx = 4'd9; ra_view = 3'd0; rb_idx = 4'd9; rb_view = 3'd2;
        #1;
        chk("R10", ra_data, 64'h5555);
        chk("R10", rb_data, 64'h5555);
        @(negedge clk);
        wr_en = 0;
        rd("R10", 4'd9, 3'd0, 64'h7777);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 0;
        t_reset();
        t_full();
        t_w32();
        t_w16();
        t_bytes();
        t_noop();
        t_hb_err();
        t_no_bypass();
        rst = 1;
        @(negedge clk);
        rst = 0;
        rd("R1", 4'd2, 3'd0, 64'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(TCK * 5000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule